// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device-side command interpreter of a serial flash memory in SPI mode 0. It samples the serial clock, chip select and data input with the system clock and detects their edges. It takes in data bits on rising serial clock edges while chip select is low and groups them into 8-bit bus cycles. The first bus cycle is the opcode. The block then collects the address, dummy and data cycles that the opcode calls for.

Read-type commands (array read, fast read, status read, identification reads) shift bytes out MSB first. A new bit appears after each falling serial clock edge, and output continues until chip select goes high. Modifying commands (byte program, the erases, status write) are checked when chip select rises. Each one that passes becomes a one-cycle request to a memory-array stub. A write-enable latch gates the modifying commands, and it clears itself once a request has been issued.

The stub answers an `arr_rd_req` with `arr_rdata` on the following clock. The system clock must run at least eight times faster than the serial clock, and each serial clock phase must last at least four system clock cycles.

Top module: `spif_cmd_front`

## Requirements
- R1: After reset, and whenever no read data is being shifted, `spi_so_oe` is low. After reset no request is issued and the status byte reads 0x00.
- R2: Opcode 0x03 followed by three address bytes (MSB first) returns array bytes from that address, then from successive addresses, until chip select rises. Addresses are truncated to ADDR_W bits, so they wrap from the top of the array to 0.
- R3: Opcode 0x0B takes three address bytes plus one ignored dummy byte, then streams data exactly as in R2.
- R4: Opcode 0x05 returns the status byte repeatedly: bits 7:2 are the protection field, bit 1 is the write-enable latch, bit 0 is 0.
- R5: Opcode 0x06 sets the write-enable latch and 0x04 clears it, together with the status-write permit. Each acts only when it is the only byte and chip select rises on a byte boundary. Otherwise it has no effect.
- R6: Opcode 0x02 with three address bytes and exactly one data byte, when the latch is set, gives a one-cycle `arr_wr_req` carrying that address and data after chip select rises. Otherwise it gives no request.
- R7: With the latch set, 0x20, 0x52 and 0xD8 followed by three address bytes give an erase request of kind 0, 1 and 2, with the address cleared below bit 12, 15 and 16 respectively. 0x60 or 0xC7 alone gives kind 3 with address 0.
- R8: Opcode 0x50 grants a status-write permit. Opcode 0x01 with one data byte, when the latch or the permit is set, gives `arr_stat_req` and loads data bits 7:2 into the protection field.
- R9: Issuing a program, erase or status-write request clears both the write-enable latch and the status-write permit.
- R10: A chip-select rise in the middle of a bus cycle abandons the command: no request is issued and the latch and permit stay unchanged.
- R11: Opcodes 0x90 and 0xAB take three address bytes. They then alternate the manufacturer ID and the device ID, starting with the device ID when address bit 0 is 1. Opcode 0x9F streams the manufacturer ID, the memory type and the device ID, repeating in that order.
- R12: An unknown opcode produces no output and no request, whatever bytes follow it.
- R13: At most one of the four request outputs is high in any cycle, and a write request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data into the device |
| spi_so | output | 1 | Serial data out of the device |
| spi_so_oe | output | 1 | Output enable for spi_so |
| arr_rd_req | output | 1 | Array read request |
| arr_addr | output | ADDR_W | Address for every array request |
| arr_rdata | input | 8 | Read data, valid the clock after arr_rd_req |
| arr_wr_req | output | 1 | Byte program request |
| arr_wdata | output | 8 | Program or status-write data |
| arr_erase_req | output | 1 | Erase request |
| arr_erase_kind | output | 2 | 0: 4 KB, 1: 32 KB, 2: 64 KB, 3: whole array |
| arr_stat_req | output | 1 | Status-write request |

## Verification
The bench targets boundary and gating cases:
- Reads that cross the top of the array. A design that did not wrap would read past the array end.
- Erase addresses with every low bit set. A wrong mask would leave stray low address bits in the request.
- Program commands with one byte too many, commands cut off after four bits, and write-enable commands carrying an extra byte. A design that executed on any chip-select rise would issue requests or change the latch here.
- The latch after a program, erase or status write. A design that forgot to clear it would read back status bit 1 still set.
- The status-write permit, which must unlock a status write when the latch is clear.
- The identification streams, checked in their alternating and three-byte orders.

// File: rtl/spif_pkg.sv
// Package: opcode values, erase kinds and output modes shared by the
// serial flash command front end. Assumes 8-bit bus cycles.
package spif_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;   // saturating count of completed bus cycles

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_ER4   = 8'h20;
    localparam logic [7:0] OP_ER32  = 8'h52;
    localparam logic [7:0] OP_ER64  = 8'hD8;
    localparam logic [7:0] OP_ERA_A = 8'h60;
    localparam logic [7:0] OP_ERA_B = 8'hC7;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_STEN  = 8'h50;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_ID_A  = 8'h90;
    localparam logic [7:0] OP_ID_B  = 8'hAB;
    localparam logic [7:0] OP_JID   = 8'h9F;

    typedef enum logic [1:0] {
        ER_4K   = 2'd0,
        ER_32K  = 2'd1,
        ER_64K  = 2'd2,
        ER_CHIP = 2'd3
    } erase_kind_t;

    typedef enum logic [2:0] {
        OM_NONE   = 3'd0,
        OM_ARRAY  = 3'd1,
        OM_STATUS = 3'd2,
        OM_RID    = 3'd3,
        OM_JID    = 3'd4
    } out_mode_t;
endpackage

// File: rtl/spif_edges.sv
// Edge detector: turns the oversampled serial clock and chip select into
// single-cycle strobes. Assumes both inputs are already synchronous to clk.
module spif_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    // Remember last-cycle levels of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_fall  = ~cs_n & cs_q;
    assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spif_rx.sv
// Receive shifter: gathers input bits MSB first into bus cycles and keeps
// the bit position and a saturating count of completed cycles per command.
// Assumes counters are only cleared by the falling edge of chip select.
module spif_rx
    import spif_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int BIT_CW = $clog2(BW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             sck_rise,
    input  logic             si,
    output logic [BIT_CW-1:0] bit_cnt,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic             byte_done,
    output logic [BW-1:0]    byte_val
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BW - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

    logic [BW-2:0] sh;

    assign byte_val  = {sh, si};
    assign byte_done = sck_rise && (bit_cnt == LAST_BIT);

    // Shift in one bit per rising edge and advance the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (cs_fall) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (sck_rise) begin
            sh      <= byte_val[BW-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT && byte_cnt != CNT_MAX)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spif_tx.sv
// Transmit shifter: loads a byte at each bus-cycle boundary on a falling
// serial clock edge and shifts it out MSB first. The enable rises at the
// first load and drops on any chip-select edge.
module spif_tx
    import spif_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_fall,
    input  logic          cs_edge,
    input  logic          active,
    input  logic          boundary,
    input  logic [BW-1:0] next_byte,
    output logic          so,
    output logic          so_oe,
    output logic          load
);
    logic [BW-1:0] tx_q;
    logic          drive_q;

    assign load  = sck_fall && active && boundary;
    assign so    = tx_q[BW-1];
    assign so_oe = drive_q;

    // Load or shift the output byte on falling edges; track output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            drive_q <= 1'b0;
        end else if (cs_edge) begin
            drive_q <= 1'b0;
        end else if (load) begin
            tx_q    <= next_byte;
            drive_q <= 1'b1;
        end else if (sck_fall && drive_q) begin
            tx_q <= {tx_q[BW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spif_cmd_front.sv
// Serial flash command front end (SPI mode 0, device side). Decodes the
// opcode, captures address and data, streams read data, status and IDs,
// and issues one-cycle requests to an array stub. Modifying commands are
// judged on the rising edge of chip select. Assumes 17 <= ADDR_W <= 24
// and at least four clk cycles per serial clock phase.
module spif_cmd_front
    import spif_pkg::*;
#(
    parameter int         ADDR_W   = 19,
    parameter logic [7:0] MFR_ID   = 8'hA5,
    parameter logic [7:0] DEV_ID   = 8'h3C,
    parameter logic [7:0] MEM_TYPE = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic              arr_rd_req,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_wr_req,
    output logic [7:0]        arr_wdata,
    output logic              arr_erase_req,
    output logic [1:0]        arr_erase_kind,
    output logic              arr_stat_req
);
    localparam int BIT_CW = $clog2(BYTE_W);

    logic sck_rise, sck_fall, cs_fall, cs_rise;
    logic [BIT_CW-1:0] bit_cnt;
    logic [CNT_W-1:0]  byte_cnt;
    logic              byte_done;
    logic [7:0]        byte_val;
    logic              tx_load;

    logic [7:0]        opcode_q, data_q, nxt_q, wdata_q;
    logic [ADDR_W-1:0] addr_q, ptr_q, erase_addr, full_addr;
    logic              wel, wsr_en;
    logic [5:0]        prot_q;
    out_mode_t         mode;
    logic [1:0]        id_idx;
    logic              rd_pend, rd_wait;
    logic              wr_req_q, er_req_q, st_req_q;
    erase_kind_t       kind, kind_q;
    logic [7:0]        cur_op, next_byte;
    logic              start_read, start_stat, start_rid, start_jid;
    logic              ok, do_wen, do_wdis, do_sten, do_prog, do_erase, do_wrst;

    spif_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    spif_rx #(.BW(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sck_rise(sck_rise),
        .si(spi_si), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    spif_tx #(.BW(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall),
        .cs_edge(cs_rise | cs_fall), .active(mode != OM_NONE),
        .boundary(bit_cnt == '0), .next_byte(next_byte),
        .so(spi_so), .so_oe(spi_so_oe), .load(tx_load)
    );

    // Opcode of the cycle in progress: the incoming byte when it is the first.
    assign cur_op    = (byte_cnt == '0) ? byte_val : opcode_q;
    assign full_addr = ADDR_W'({addr_q, byte_val});

    assign start_read = byte_done && ((cur_op == OP_READ  && byte_cnt == 3'd3) ||
                                      (cur_op == OP_FREAD && byte_cnt == 3'd4));
    assign start_stat = byte_done && cur_op == OP_RDST && byte_cnt == 3'd0;
    assign start_rid  = byte_done && (cur_op == OP_ID_A || cur_op == OP_ID_B) &&
                        byte_cnt == 3'd3;
    assign start_jid  = byte_done && cur_op == OP_JID && byte_cnt == 3'd0;

    // Modifying commands are judged when chip select rises on a whole byte.
    assign ok       = cs_rise && (bit_cnt == '0);
    assign do_wen   = ok && opcode_q == OP_WEN  && byte_cnt == 3'd1;
    assign do_wdis  = ok && opcode_q == OP_WDIS && byte_cnt == 3'd1;
    assign do_sten  = ok && opcode_q == OP_STEN && byte_cnt == 3'd1;
    assign do_prog  = ok && wel && opcode_q == OP_PROG && byte_cnt == 3'd5;
    assign do_erase = ok && wel &&
        (((opcode_q == OP_ER4 || opcode_q == OP_ER32 || opcode_q == OP_ER64) &&
          byte_cnt == 3'd4) ||
         ((opcode_q == OP_ERA_A || opcode_q == OP_ERA_B) && byte_cnt == 3'd1));
    assign do_wrst  = ok && (wel || wsr_en) && opcode_q == OP_WRST && byte_cnt == 3'd2;

    // Select the erase kind and clear the address bits below the region size.
    always_comb begin
        unique case (opcode_q)
            OP_ER4: begin
                kind = ER_4K;
                erase_addr = addr_q & ~ADDR_W'((1 << 12) - 1);
            end
            OP_ER32: begin
                kind = ER_32K;
                erase_addr = addr_q & ~ADDR_W'((1 << 15) - 1);
            end
            OP_ER64: begin
                kind = ER_64K;
                erase_addr = addr_q & ~ADDR_W'((1 << 16) - 1);
            end
            default: begin
                kind = ER_CHIP;
                erase_addr = '0;
            end
        endcase
    end

    // Pick the byte to load at the next output boundary.
    always_comb begin
        unique case (mode)
            OM_ARRAY:  next_byte = nxt_q;
            OM_STATUS: next_byte = {prot_q, wel, 1'b0};
            OM_RID:    next_byte = id_idx[0] ? DEV_ID : MFR_ID;
            OM_JID:    next_byte = (id_idx == 2'd0) ? MFR_ID :
                                   (id_idx == 2'd1) ? MEM_TYPE : DEV_ID;
            default:   next_byte = 8'h00;
        endcase
    end

    // Capture the opcode, address bytes and data byte of a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
        end else if (byte_done) begin
            if (byte_cnt == 3'd0) opcode_q <= byte_val;
            if (byte_cnt >= 3'd1 && byte_cnt <= 3'd3) addr_q <= full_addr;
            if (byte_cnt == 3'd1 || byte_cnt == 3'd4) data_q <= byte_val;
        end
    end

    // Maintain the write-enable latch, status-write permit and protection field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel    <= 1'b0;
            wsr_en <= 1'b0;
            prot_q <= '0;
        end else begin
            if (do_prog || do_erase || do_wrst || do_wdis) begin
                wel    <= 1'b0;
                wsr_en <= 1'b0;
            end else if (do_wen) begin
                wel <= 1'b1;
            end else if (do_sten) begin
                wsr_en <= 1'b1;
            end
            if (do_wrst) prot_q <= data_q[7:2];
        end
    end

    // Sequence output modes, read prefetch and ID order; set request address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= OM_NONE;
            ptr_q   <= '0;
            id_idx  <= '0;
            rd_pend <= 1'b0;
            rd_wait <= 1'b0;
            nxt_q   <= '0;
        end else begin
            rd_pend <= 1'b0;
            rd_wait <= rd_pend;
            if (rd_wait) nxt_q <= arr_rdata;
            if (cs_rise || cs_fall) begin
                mode <= OM_NONE;
                if (do_prog)  ptr_q <= addr_q;
                if (do_erase) ptr_q <= erase_addr;
            end else if (start_read) begin
                mode    <= OM_ARRAY;
                ptr_q   <= (cur_op == OP_FREAD) ? addr_q : full_addr;
                rd_pend <= 1'b1;
            end else if (start_stat) begin
                mode <= OM_STATUS;
            end else if (start_rid) begin
                mode   <= OM_RID;
                id_idx <= {1'b0, byte_val[0]};
            end else if (start_jid) begin
                mode   <= OM_JID;
                id_idx <= 2'd0;
            end else if (tx_load) begin
                unique case (mode)
                    OM_ARRAY: begin
                        ptr_q   <= ptr_q + 1'b1;
                        rd_pend <= 1'b1;
                    end
                    OM_RID:  id_idx[0] <= ~id_idx[0];
                    OM_JID:  id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Register the modifying requests one cycle after chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req_q <= 1'b0;
            er_req_q <= 1'b0;
            st_req_q <= 1'b0;
            kind_q   <= ER_4K;
            wdata_q  <= '0;
        end else begin
            wr_req_q <= do_prog;
            er_req_q <= do_erase;
            st_req_q <= do_wrst;
            if (do_erase) kind_q <= kind;
            if (do_prog || do_wrst) wdata_q <= data_q;
        end
    end

    assign arr_rd_req     = rd_pend;
    assign arr_addr       = ptr_q;
    assign arr_wr_req     = wr_req_q;
    assign arr_wdata      = wdata_q;
    assign arr_erase_req  = er_req_q;
    assign arr_erase_kind = kind_q;
    assign arr_stat_req   = st_req_q;
endmodule

// File: rtl/spif_cmd_front_chk.sv
// Checker for the serial flash command front end: temporal rules on the
// output enable, the request outputs and the write-enable latch.
module spif_cmd_front_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_so_oe,
    input logic              arr_rd_req,
    input logic              arr_wr_req,
    input logic              arr_erase_req,
    input logic [1:0]        arr_erase_kind,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_stat_req,
    input logic              wel
);
    assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n)) |-> !spi_so_oe);

    assert_oe_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_so_oe) |-> !spi_cs_n);

    assert_req_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd_req, arr_wr_req, arr_erase_req, arr_stat_req}));

    assert_wr_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_req |=> !arr_wr_req);

    assert_latch_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req || arr_erase_req || arr_stat_req) |-> !wel);

    assert_exec_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req || arr_erase_req || arr_stat_req) |-> spi_cs_n);

    assert_er4_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_erase_req && arr_erase_kind == 2'd0) |->
        ((arr_addr & ADDR_W'(12'hFFF)) == '0));

    assert_er64_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_erase_req && arr_erase_kind == 2'd2) |->
        ((arr_addr & ADDR_W'(16'hFFFF)) == '0));
endmodule

bind spif_cmd_front spif_cmd_front_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .arr_rd_req(arr_rd_req), .arr_wr_req(arr_wr_req),
    .arr_erase_req(arr_erase_req), .arr_erase_kind(arr_erase_kind),
    .arr_addr(arr_addr), .arr_stat_req(arr_stat_req), .wel(wel)
);

// File: tb/test_spif_cmd_front.sv
// Bench for the serial flash command front end. Drives SPI mode 0 with four
// clk cycles per serial clock phase; array content is a computed pattern.
module test_spif_cmd_front;
    localparam int AW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so, so_oe, rd_req, wr_req, er_req, st_req;
    logic [AW-1:0] addr;
    logic [7:0] rdata = 8'h00, wdata;
    logic [1:0] kind;

    int n_tests = 0, n_fail = 0;
    int n_wr = 0, n_er = 0, n_st = 0;
    logic [AW-1:0] last_addr;
    logic [7:0] last_wdata;
    logic [1:0] last_kind;
    logic [7:0] rbuf [0:7];
    logic hdr_oe;
    bit done = 0;

    always #4 clk = ~clk;

    spif_cmd_front i_spif_cmd_front (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .arr_rd_req(rd_req), .arr_addr(addr),
        .arr_rdata(rdata), .arr_wr_req(wr_req), .arr_wdata(wdata),
        .arr_erase_req(er_req), .arr_erase_kind(kind), .arr_stat_req(st_req)
    );

    function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    // Array stub and request monitor.
    always @(posedge clk) begin
        if (rd_req) rdata <= mem_f(addr);
        if (wr_req) begin n_wr <= n_wr + 1; last_addr <= addr; last_wdata <= wdata; end
        if (er_req) begin n_er <= n_er + 1; last_addr <= addr; last_kind <= kind; end
        if (st_req) begin n_st <= n_st + 1; last_wdata <= wdata; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r, output logic oe_seen);
        oe_seen = 1'b0;
        r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) si = b[i];
            repeat (3) @(negedge clk);
            r[i] = so;
            if (so_oe) oe_seen = 1'b1;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic part_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk) si = b[i];
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic hdr(input logic [7:0] b);
        logic [7:0] r;
        logic o;
        xfer(b, r, o);
        if (o) hdr_oe = 1'b1;
    endtask

    // Command with header bytes then n output bytes captured into rbuf.
    task automatic stream(input logic [7:0] op, input logic [23:0] a,
                          input int naddr, input int ndummy, input int n);
        logic o;
        hdr_oe = 1'b0;
        cs_begin();
        hdr(op);
        for (int k = naddr - 1; k >= 0; k--) hdr(a[8*k +: 8]);
        for (int k = 0; k < ndummy; k++) hdr(8'hFF);
        for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k], o);
        cs_end();
    endtask

    task automatic simple(input logic [7:0] op);
        cs_begin(); hdr(op); cs_end();
    endtask

    task automatic status(input string req, input logic [7:0] exp);
        stream(8'h05, 24'h0, 0, 0, 3);
        for (int k = 0; k < 3; k++) chk(req, rbuf[k], exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int w0, e0, s0;
        logic [23:0] starts [4];
        logic [7:0] eops [5];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 oe after reset", so_oe, 0);
        chk("R1 no requests after reset", n_wr + n_er + n_st, 0);
        status("R1 R4 status after reset", 8'h00);

        // R2: array read sweep including wrap and upper bits dropped
        starts = '{24'h000000, 24'h012345, 24'h07FFFE, 24'hFABCDE};
        foreach (starts[s]) begin
            stream(8'h03, starts[s], 3, 0, 4);
            chk("R1 R2 no output during header", hdr_oe, 0);
            for (int k = 0; k < 4; k++)
                chk("R2 read data", rbuf[k], mem_f(AW'(starts[s] + k)));
        end

        // R3: fast read with dummy byte, crossing the top
        stream(8'h0B, 24'h07FFFD, 3, 1, 5);
        chk("R3 no output during header/dummy", hdr_oe, 0);
        for (int k = 0; k < 5; k++)
            chk("R3 fast read data", rbuf[k], mem_f(AW'(24'h07FFFD + k)));

        // R11: identification streams
        stream(8'h90, 24'h000000, 3, 0, 4);
        chk("R11 id bit0=0 b0", rbuf[0], 8'hA5); chk("R11 id b1", rbuf[1], 8'h3C);
        chk("R11 id b2", rbuf[2], 8'hA5);        chk("R11 id b3", rbuf[3], 8'h3C);
        stream(8'hAB, 24'h000001, 3, 0, 3);
        chk("R11 id bit0=1 b0", rbuf[0], 8'h3C); chk("R11 id b1", rbuf[1], 8'hA5);
        chk("R11 id b2", rbuf[2], 8'h3C);
        stream(8'h9F, 24'h0, 0, 0, 4);
        chk("R11 jedec b0", rbuf[0], 8'hA5); chk("R11 jedec b1", rbuf[1], 8'h25);
        chk("R11 jedec b2", rbuf[2], 8'h3C); chk("R11 jedec b3", rbuf[3], 8'hA5);

        // R12: unknown opcode
        w0 = n_wr; e0 = n_er; s0 = n_st;
        stream(8'hFF, 24'h123456, 3, 0, 2);
        chk("R12 no output on unknown opcode", hdr_oe | so_oe, 0);
        chk("R12 no request on unknown opcode", (n_wr - w0) + (n_er - e0) + (n_st - s0), 0);

        // R6: program without latch
        w0 = n_wr;
        cs_begin(); hdr(8'h02); hdr(8'h01); hdr(8'h23); hdr(8'h45); hdr(8'h9C); cs_end();
        chk("R6 no program without latch", n_wr - w0, 0);

        // R5 R6 R9 R13: latch then program
        simple(8'h06);
        status("R5 latch set", 8'h02);
        cs_begin(); hdr(8'h02); hdr(8'h01); hdr(8'h23); hdr(8'h45); hdr(8'h9C); cs_end();
        chk("R6 R13 one program request", n_wr - w0, 1);
        chk("R6 program address", last_addr, 19'h12345);
        chk("R6 program data", last_wdata, 8'h9C);
        status("R9 latch cleared after program", 8'h00);

        // R6: extra byte, R10: cut mid-byte
        simple(8'h06);
        w0 = n_wr;
        cs_begin(); hdr(8'h02); hdr(8'h00); hdr(8'h00); hdr(8'h10);
        hdr(8'h11); hdr(8'h22); cs_end();
        chk("R6 no program with extra byte", n_wr - w0, 0);
        cs_begin(); hdr(8'h02); hdr(8'h00); hdr(8'h00); hdr(8'h10);
        part_bits(8'h77, 4); cs_end();
        chk("R10 no program when cut", n_wr - w0, 0);
        status("R10 latch kept after cut", 8'h02);

        // R5: disable, extra byte, cut enable
        simple(8'h04);
        status("R5 latch cleared by disable", 8'h00);
        cs_begin(); hdr(8'h06); hdr(8'h00); cs_end();
        status("R5 enable with extra byte ignored", 8'h00);
        cs_begin(); part_bits(8'h06, 5); cs_end();
        status("R10 cut enable ignored", 8'h00);

        // R7: erase sweep with all low address bits set
        eops = '{8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7};
        foreach (eops[j]) begin
            logic [1:0] ek;
            logic [AW-1:0] ea;
            ek = (j < 3) ? 2'(j) : 2'd3;
            ea = (j == 0) ? 19'h7F000 : (j == 1) ? 19'h78000 : (j == 2) ? 19'h70000 : 19'h0;
            simple(8'h06);
            e0 = n_er;
            cs_begin(); hdr(eops[j]);
            if (j < 3) begin hdr(8'h07); hdr(8'hFF); hdr(8'hFF); end
            cs_end();
            chk("R7 one erase request", n_er - e0, 1);
            chk("R7 erase kind", last_kind, ek);
            chk("R7 erase address", last_addr, ea);
            status("R9 latch cleared after erase", 8'h00);
        end
        e0 = n_er;
        cs_begin(); hdr(8'h20); hdr(8'h00); hdr(8'h10); hdr(8'h00); cs_end();
        chk("R7 no erase without latch", n_er - e0, 0);

        // R8: status write gating and effect
        s0 = n_st;
        cs_begin(); hdr(8'h01); hdr(8'hFC); cs_end();
        chk("R8 no status write without permit", n_st - s0, 0);
        status("R8 protection unchanged", 8'h00);
        simple(8'h50);
        cs_begin(); hdr(8'h01); hdr(8'hFC); cs_end();
        chk("R8 status write with permit", n_st - s0, 1);
        chk("R8 status write data", last_wdata, 8'hFC);
        status("R8 protection loaded", 8'hFC);
        cs_begin(); hdr(8'h01); hdr(8'h00); cs_end();
        chk("R9 permit consumed", n_st - s0, 1);
        simple(8'h06);
        status("R4 status with latch", 8'hFE);
        cs_begin(); hdr(8'h01); hdr(8'h00); cs_end();
        chk("R8 status write with latch", n_st - s0, 2);
        status("R8 R9 protection cleared, latch cleared", 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule